// File: doc/BRIEF.md
# Self-Clearing Timed Discharge Control Bit

This block holds one host-writable control bit that turns on a pull-down discharge of a battery-side capacitor. The pull-down lets a fuel-gauge device enter its shipping state. When the host writes a 1, the bit goes high and the discharge-enable output is asserted. The bit stays high for a fixed number of time-base ticks, then clears itself and the discharge stops. The default is 140 ticks of a 1 ms strobe, which gives 140 ms.

The host can stop a discharge at any time by writing 0. It can run another full-length cycle by writing 1 again. A write of 1 during a running cycle restarts the period from zero. The register readback shows the live state of the bit. The current sink and any check on the resulting voltage are outside this block. The host decides whether another cycle is needed.

Inputs are the host write strobe with its data bit and a one-cycle tick pulse at the time-base rate. The block runs on a single clock and uses a synchronous active-low reset.

Top module: `ship_discharge_bit`

## Requirements
- R1: A host write with data 1 sets the bit and the discharge enable on the clock edge that captures the write, and starts the period count at zero.
- R2: With no further writes, the bit clears on the edge that captures the PERIOD_TICKS-th tick after the start. The bit is high while PERIOD_TICKS-1 ticks are seen and low after the PERIOD_TICKS-th tick.
- R3: A host write with data 0 clears the bit and the discharge enable on the edge that captures the write, whatever the count is.
- R4: After an automatic clear, a new write of 1 starts a fresh period of full length.
- R5: A write of 1 while the bit is already set restarts the count. The bit then clears PERIOD_TICKS ticks after the rewrite, not after the first write.
- R6: After reset the bit and the discharge enable are 0.
- R7: Ticks have no effect while the bit is 0, and writing 0 while the bit is 0 leaves it at 0.
- R8: A host write wins over the final tick in the same cycle. Data 1 keeps the bit high and starts a fresh full period. Data 0 clears the bit.
- R9: The readback output always equals the discharge-enable output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse at the time-base rate |
| host_wr_i | input | 1 | Host write strobe for the control bit |
| host_wdata_i | input | 1 | Data bit of the host write |
| dchg_en_o | output | 1 | Discharge enable to the current sink |
| bit_rd_o | output | 1 | Live state of the control bit for readback |

## Verification
The case that matters most is a host write that lands in the same cycle as the tick that would end the period. The bench first counts the time base up to one tick short of expiry. It then drives the final tick and a write together, once with data 1 and once with data 0. The reference model gives the write priority and is compared against the outputs on every clock. Afterwards the bench checks that a write of 1 produced a complete fresh period and that a write of 0 left the bit clear.

// File: rtl/ship_discharge_pkg.sv
// Package: types shared by the timed discharge control bit.
// Assumes: one host command at most per clock cycle.
package ship_discharge_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_START = 2'b01,
        CMD_ABORT = 2'b10
    } host_cmd_e;

endpackage

// File: rtl/ship_discharge_cmd.sv
// Module: turns the host write strobe and data bit into a command.
// Assumes: the strobe lasts one cycle for each host write.
module ship_discharge_cmd
    import ship_discharge_pkg::*;
(
    input  logic      wr_i,
    input  logic      wdata_i,
    output host_cmd_e cmd_o
);

    // Decode the write into start, abort or nothing.
    always_comb begin
        if (!wr_i)        cmd_o = CMD_NONE;
        else if (wdata_i) cmd_o = CMD_START;
        else              cmd_o = CMD_ABORT;
    end

endmodule

// File: rtl/ship_discharge_timer.sv
// Module: counts time-base ticks during a discharge and flags the final tick.
// Assumes: clear_i has priority over counting; PERIOD_TICKS >= 2.
module ship_discharge_timer #(
    parameter int unsigned PERIOD_TICKS = 140
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic done_o
);

    localparam int unsigned CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Flag the tick that completes the period.
    assign done_o = run_i && (cnt_q == LAST);

    // Count ticks while running; wrap to zero on expiry or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (done_o)  cnt_q <= '0;
        else if (run_i)   cnt_q <= cnt_q + 1'b1;
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    a_r1_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !run_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ship_discharge_state.sv
// Module: holds the live control bit; a host command wins over expiry.
// Assumes: done_i can be high only while the bit is set.
module ship_discharge_state
    import ship_discharge_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  host_cmd_e cmd_i,
    input  logic      done_i,
    output logic      active_o
);

    // Update the bit from the host command, else from expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                  active_o <= 1'b0;
        else if (cmd_i == CMD_START) active_o <= 1'b1;
        else if (cmd_i == CMD_ABORT) active_o <= 1'b0;
        else if (done_i)             active_o <= 1'b0;
    end

    a_r1_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_START) |=> active_o);

    a_r3_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ABORT) |=> !active_o);

    a_r2_expiry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cmd_i == CMD_NONE) |=> !active_o);

    a_r7_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && cmd_i != CMD_START) |=> !active_o);

    a_r2_done_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> active_o);

endmodule

// File: rtl/ship_discharge_bit.sv
// Module: top of the self-clearing timed discharge control bit.
// Assumes: tick_i is a single-cycle pulse; one period = PERIOD_TICKS ticks.
module ship_discharge_bit
    import ship_discharge_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 140
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic host_wr_i,
    input  logic host_wdata_i,
    output logic dchg_en_o,
    output logic bit_rd_o
);

    host_cmd_e cmd;
    logic      active;
    logic      done;
    logic      run;

    ship_discharge_cmd u_cmd (
        .wr_i    (host_wr_i),
        .wdata_i (host_wdata_i),
        .cmd_o   (cmd)
    );

    // Ticks advance the count only while a discharge is running.
    assign run = active && tick_i;

    ship_discharge_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cmd != CMD_NONE),
        .run_i   (run),
        .done_o  (done)
    );

    ship_discharge_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .done_i   (done),
        .active_o (active)
    );

    // Drive the sink enable and the readback from the same live bit.
    assign dchg_en_o = active;
    assign bit_rd_o  = active;

endmodule

// File: tb/ship_discharge_bit_tb.sv
module ship_discharge_bit_tb;

    localparam int P = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic we = 1'b0;
    logic wd = 1'b0;
    logic dchg;
    logic rd;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string req = "R6";
    bit    m_act = 1'b0;
    int    m_left = 0;

    always #5 clk = ~clk;

    ship_discharge_bit #(.PERIOD_TICKS(P)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .host_wr_i    (we),
        .host_wdata_i (wd),
        .dchg_en_o    (dchg),
        .bit_rd_o     (rd)
    );

    task automatic chk(string r, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", r, act, exp, cycles);
        end
    endtask

    task automatic cyc(bit t, bit w, bit d);
        @(negedge clk);
        tick = t;
        we = w;
        wd = d;
    endtask

    task automatic idle_ticks(int n);
        for (int i = 0; i < n; i++) cyc((i % 3) == 2, 1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Behavioural reference: remaining ticks, with the host write taking priority.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_act = 1'b0;
            m_left = 0;
        end else if (we && wd) begin
            m_act = 1'b1;
            m_left = P;
        end else if (we) begin
            m_act = 1'b0;
            m_left = 0;
        end else if (m_act && tick) begin
            m_left = m_left - 1;
            if (m_left == 0) m_act = 1'b0;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk(req, dchg, m_act);
            chk("R9", rd, dchg);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        // R6: reset state
        req = "R6";
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        chk("R6", rd, 1'b0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);

        // R7: ticks and a write of 0 while idle
        req = "R7";
        idle_ticks(9);
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R7", rd, 1'b0);

        // R1/R2: full period with a tick every cycle
        req = "R2";
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R1", rd, 1'b1);
        repeat (P - 1) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R2", rd, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R2", rd, 1'b0);

        // R4: fresh period after a self-clear, sparse ticks
        req = "R4";
        cyc(1'b0, 1'b1, 1'b1);
        idle_ticks(3 * P - 1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R4", rd, 1'b1);
        idle_ticks(6);
        chk("R4", rd, 1'b0);

        // R3: abort mid-period
        req = "R3";
        cyc(1'b0, 1'b1, 1'b1);
        repeat (2) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R3", rd, 1'b0);
        idle_ticks(6);

        // R5: rewrite of 1 mid-period restarts the count
        req = "R5";
        cyc(1'b0, 1'b1, 1'b1);
        repeat (P - 2) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1);
        repeat (P - 1) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R5", rd, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R5", rd, 1'b0);

        // R8: write of 1 in the same cycle as the final tick
        req = "R8";
        cyc(1'b0, 1'b1, 1'b1);
        repeat (P - 1) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R8", rd, 1'b1);
        repeat (P - 1) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R8", rd, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R8", rd, 1'b0);

        // R8: write of 0 in the same cycle as the final tick
        cyc(1'b0, 1'b1, 1'b1);
        repeat (P - 1) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R8", rd, 1'b0);
        idle_ticks(6);
        chk("R7", rd, 1'b0);

        summary();
    end

endmodule